// File: doc/BRIEF.md
# Display Memory Logical Write Unit

This block carries out logical writes into a word-organised display memory. A request names a target (whole 16-bit word, low byte only, or high byte only), a logical combine mode, a 16-bit data word and a repeat count. The unit performs count + 1 writes at the execute address. After each write it moves that address by one step in one of eight drawing directions, where a vertical step is one row pitch.

Replace mode writes the data directly. The XOR, clear and set modes first read the stored word, combine it with the data and then write the result back. A request that uses the unused target code 1 is dropped. The execute address is loaded through a dedicated port while the unit is idle, and it is visible at all times. A one-cycle done pulse follows every memory write. The memory port returns read data on the cycle after the read strobe.

Top module: `dmem_logic_wr`

## Requirements
- R1: After reset `busy_o`, `done_o`, `mem_rd_o` and `mem_wr_o` are low, `mem_be_o` is 0 and `ead_o` is 0.
- R2: Mode 0 (replace) puts the data into the target lanes and issues no read. Each element takes one cycle, and the first write strobe appears in the cycle right after acceptance.
- R3: Mode 1 writes the stored value XOR the data into the target lanes.
- R4: Mode 2 writes the stored value AND NOT the data into the target lanes.
- R5: In modes 1, 2 and 3, every write comes directly after a read of the same address one cycle earlier, so each element takes two cycles. Mode 3 writes the stored value OR the data.
- R6: Target code 0 writes both lanes (`mem_be_o`=2'b11). Code 2 writes bits 7:0 from data bits 7:0 (`mem_be_o`=2'b01). Code 3 writes bits 15:8 from data bits 15:8 (`mem_be_o`=2'b10). Whenever `mem_wr_o` is low, `mem_be_o` is 0.
- R7: A request with target code 1 is ignored: there is no memory strobe, `busy_o` stays low and `ead_o` is unchanged.
- R8: After each write, `ead_o` becomes (ead + dx + dy*pitch) mod 2^18. Direction codes 0..7 give (dx,dy) = (0,+1), (+1,+1), (+1,0), (+1,-1), (0,-1), (-1,-1), (-1,0), (-1,+1).
- R9: One request with count N performs exactly N+1 writes, all using the same data.
- R10: `done_o` is high for exactly the one cycle that follows each write strobe.
- R11: While `busy_o` is high, new requests and address loads have no effect.
- R12: While idle, an address load that arrives in the same cycle as an accepted request takes effect, and the first memory access of that request uses the loaded address. A request arriving in the cycle of the final done pulse is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Write request strobe, taken when idle |
| req_type_i | input | 2 | Target: 0 word, 2 low byte, 3 high byte, 1 rejected |
| req_mode_i | input | 2 | Combine: 0 replace, 1 XOR, 2 clear, 3 set |
| req_data_i | input | 16 | Data word |
| req_count_i | input | 14 | Repeat count; count+1 writes |
| ead_load_i | input | 1 | Load execute address when idle |
| ead_i | input | 18 | Execute address to load |
| dir_i | input | 3 | Drawing direction code |
| pitch_i | input | 8 | Row pitch in words |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | Pulse after each write |
| ead_o | output | 18 | Current execute address |
| mem_addr_o | output | 18 | Memory word address |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_be_o | output | 2 | Byte lane enables for write |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Read data, valid the cycle after the read strobe |

## Verification
Two pairs of events can fall in the same cycle. The first pair is an address load and the acceptance of a request. The second is the final done pulse of one request and the acceptance of the next. The bench drives the load and the request on the same clock edge, and it also starts a second request exactly on the cycle where `done_o` of the first is high. A behavioural reference memory and address model then predicts every strobe, and a strobe is wrong if it is out of order, uses the wrong address, or carries the wrong byte enables or data. The bench also injects a request and a load while the unit is busy, and it confirms through the strobe stream and the final `ead_o` that neither one had any effect.

// File: rtl/dmw_pkg.sv
package dmw_pkg;
  typedef enum logic [1:0] {
    LM_REPLACE = 2'd0,
    LM_XOR     = 2'd1,
    LM_CLEAR   = 2'd2,
    LM_SET     = 2'd3
  } lmode_e;

  typedef enum logic [1:0] {
    TG_WORD = 2'd0,
    TG_BAD  = 2'd1,
    TG_LO   = 2'd2,
    TG_HI   = 2'd3
  } tgt_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } st_e;
endpackage

// File: rtl/dmw_combine.sv
module dmw_combine
  import dmw_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8
) (
  input  logic [1:0]        mode_i,
  input  logic [1:0]        tgt_i,
  input  logic [DATA_W-1:0] old_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] wdata_o,
  output logic [LANES-1:0]  be_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] o_b, d_b;
    assign o_b = old_i[8*l +: 8];
    assign d_b = data_i[8*l +: 8];

    always_comb begin
      unique case (lmode_e'(mode_i))
        LM_REPLACE: wdata_o[8*l +: 8] = d_b;
        LM_XOR:     wdata_o[8*l +: 8] = o_b ^ d_b;
        LM_CLEAR:   wdata_o[8*l +: 8] = o_b & ~d_b;
        default:    wdata_o[8*l +: 8] = o_b | d_b;
      endcase
    end

    // lane 0 = low byte, lane 1 = high byte
    assign be_o[l] = (tgt_i == TG_WORD) ||
                     ((tgt_i == TG_LO) && (l == 0)) ||
                     ((tgt_i == TG_HI) && (l == 1));
  end
endmodule

// File: rtl/dmw_step.sv
module dmw_step #(
  parameter int ADDR_W  = 18,
  parameter int PITCH_W = 8
) (
  input  logic [ADDR_W-1:0]  ead_i,
  input  logic [2:0]         dir_i,
  input  logic [PITCH_W-1:0] pitch_i,
  output logic [ADDR_W-1:0]  ead_o
);
  logic dx_pos, dx_neg, dy_pos, dy_neg;
  logic [ADDR_W-1:0] p_ext, dx_term, dy_term;

  always_comb begin
    dx_pos = (dir_i == 3'd1) || (dir_i == 3'd2) || (dir_i == 3'd3);
    dx_neg = (dir_i == 3'd5) || (dir_i == 3'd6) || (dir_i == 3'd7);
    dy_pos = (dir_i == 3'd0) || (dir_i == 3'd1) || (dir_i == 3'd7);
    dy_neg = (dir_i == 3'd3) || (dir_i == 3'd4) || (dir_i == 3'd5);
  end

  assign p_ext   = ADDR_W'(pitch_i);
  assign dx_term = dx_pos ? ADDR_W'(1) : (dx_neg ? '1 : '0);
  assign dy_term = dy_pos ? p_ext : (dy_neg ? (~p_ext + ADDR_W'(1)) : '0);
  // modulo 2^ADDR_W by truncation
  assign ead_o   = ead_i + dx_term + dy_term;
endmodule

// File: rtl/dmw_seq.sv
module dmw_seq
  import dmw_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [1:0]       req_type_i,
  input  logic [1:0]       req_mode_i,
  input  logic [CNT_W-1:0] req_count_i,
  output logic             accept_o,
  output logic             idle_o,
  output logic             rd_o,
  output logic             wr_o,
  output logic             done_o,
  output logic [1:0]       mode_o,
  output logic [1:0]       tgt_o
);
  st_e              st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       mode_q, tgt_q;
  logic             done_q;

  assign idle_o   = (st_q == ST_IDLE);
  assign accept_o = idle_o && req_valid_i && (req_type_i != TG_BAD);
  assign rd_o     = (st_q == ST_RD);
  assign wr_o     = (st_q == ST_WR);
  assign done_o   = done_q;
  assign mode_o   = mode_q;
  assign tgt_o    = tgt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      mode_q <= '0;
      tgt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= wr_o;
      unique case (st_q)
        ST_IDLE: if (accept_o) begin
          mode_q <= req_mode_i;
          tgt_q  <= req_type_i;
          cnt_q  <= req_count_i;
          st_q   <= (req_mode_i == LM_REPLACE) ? ST_WR : ST_RD;
        end
        ST_RD: st_q <= ST_WR;
        ST_WR: begin
          if (cnt_q == '0) begin
            st_q <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
            st_q  <= (mode_q == LM_REPLACE) ? ST_WR : ST_RD;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dmem_logic_wr.sv
module dmem_logic_wr #(
  parameter int ADDR_W  = 18,
  parameter int DATA_W  = 16,
  parameter int PITCH_W = 8,
  parameter int CNT_W   = 14,
  localparam int LANES  = DATA_W / 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [1:0]         req_type_i,
  input  logic [1:0]         req_mode_i,
  input  logic [DATA_W-1:0]  req_data_i,
  input  logic [CNT_W-1:0]   req_count_i,
  input  logic               ead_load_i,
  input  logic [ADDR_W-1:0]  ead_i,
  input  logic [2:0]         dir_i,
  input  logic [PITCH_W-1:0] pitch_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [ADDR_W-1:0]  ead_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic               mem_rd_o,
  output logic               mem_wr_o,
  output logic [LANES-1:0]   mem_be_o,
  output logic [DATA_W-1:0]  mem_wdata_o,
  input  logic [DATA_W-1:0]  mem_rdata_i
);
  logic              accept, idle, rd, wr;
  logic [1:0]        mode, tgt;
  logic [DATA_W-1:0] data_q, comb_wdata;
  logic [LANES-1:0]  comb_be;
  logic [ADDR_W-1:0] ead_q, ead_nxt;

  dmw_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_type_i  (req_type_i),
    .req_mode_i  (req_mode_i),
    .req_count_i (req_count_i),
    .accept_o    (accept),
    .idle_o      (idle),
    .rd_o        (rd),
    .wr_o        (wr),
    .done_o      (done_o),
    .mode_o      (mode),
    .tgt_o       (tgt)
  );

  dmw_combine #(.DATA_W(DATA_W)) u_comb (
    .mode_i  (mode),
    .tgt_i   (tgt),
    .old_i   (mem_rdata_i),
    .data_i  (data_q),
    .wdata_o (comb_wdata),
    .be_o    (comb_be)
  );

  dmw_step #(.ADDR_W(ADDR_W), .PITCH_W(PITCH_W)) u_step (
    .ead_i   (ead_q),
    .dir_i   (dir_i),
    .pitch_i (pitch_i),
    .ead_o   (ead_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ead_q  <= '0;
      data_q <= '0;
    end else begin
      if (accept) data_q <= req_data_i;
      if (idle && ead_load_i) ead_q <= ead_i;
      else if (wr)            ead_q <= ead_nxt;
    end
  end

  assign busy_o      = !idle;
  assign ead_o       = ead_q;
  assign mem_addr_o  = ead_q;
  assign mem_rd_o    = rd;
  assign mem_wr_o    = wr;
  assign mem_be_o    = wr ? comb_be : '0;
  assign mem_wdata_o = comb_wdata;
endmodule

// File: rtl/dmw_checker.sv
module dmw_checker #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [1:0]        req_type_i,
  input logic [2:0]        dir_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] ead_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_rd_o,
  input logic              mem_wr_o,
  input logic [LANES-1:0]  mem_be_o
);
  a_r10_done_follows_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |=> done_o);
  a_r10_done_only_after_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(mem_wr_o));
  a_r5_rd_then_wr_same_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> (mem_wr_o && mem_addr_o == $past(mem_addr_o)));
  a_r5_no_rd_wr_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));
  a_r6_be_on_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> (mem_be_o != '0));
  a_r6_be_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_wr_o |-> (mem_be_o == '0));
  a_r7_bad_type_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_type_i == 2'd1 && !busy_o) |=> !busy_o);
  a_r11_ead_hold_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !mem_wr_o) |=> $stable(ead_o));
  a_r8_step_right: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o && dir_i == 3'd2) |=> (ead_o == ADDR_W'($past(ead_o) + 1'b1)));
endmodule

bind dmem_logic_wr dmw_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/dmem_logic_wr_tb_top.sv
module dmem_logic_wr_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_type = '0, req_mode = '0;
  logic [15:0] req_data = '0;
  logic [13:0] req_count = '0;
  logic        ead_load = 1'b0;
  logic [17:0] ead_in = '0;
  logic [2:0]  dir = '0;
  logic [7:0]  pitch = '0;
  logic        busy, done, mem_rd, mem_wr;
  logic [17:0] ead, mem_addr;
  logic [1:0]  mem_be;
  logic [15:0] mem_wdata, mem_rdata = '0;

  always #5 clk = ~clk;

  dmem_logic_wr dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_type_i(req_type),
    .req_mode_i(req_mode), .req_data_i(req_data), .req_count_i(req_count),
    .ead_load_i(ead_load), .ead_i(ead_in), .dir_i(dir), .pitch_i(pitch),
    .busy_o(busy), .done_o(done), .ead_o(ead), .mem_addr_o(mem_addr),
    .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .mem_be_o(mem_be),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata));

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;
  string cur_tag = "R1";

  // memory seen by the DUT
  logic [15:0] dmem [int];
  // reference memory and address
  logic [15:0] rmem [int];
  int ref_ead = 0;
  int ex_kind[$], ex_addr[$], ex_be[$], ex_wd[$];

  function automatic logic [15:0] seedv(int a);
    return 16'((a * 7) & 16'hffff) ^ 16'h3c96;
  endfunction

  function automatic logic [15:0] drd(int a);
    return dmem.exists(a) ? dmem[a] : seedv(a);
  endfunction

  function automatic logic [15:0] rrd(int a);
    return rmem.exists(a) ? rmem[a] : seedv(a);
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= drd(int'(mem_addr));
    if (mem_wr) begin
      logic [15:0] v;
      v = drd(int'(mem_addr));
      if (mem_be[0]) v[7:0]  = mem_wdata[7:0];
      if (mem_be[1]) v[15:8] = mem_wdata[15:8];
      dmem[int'(mem_addr)] = v;
    end
  end

  // per-cycle comparison against the reference stream
  bit prev_wr = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (done || prev_wr)
        chk(done == prev_wr, "R10", "done pulse", done, prev_wr);
      if (mem_rd || mem_wr) begin
        if (ex_kind.size() == 0) begin
          chk(0, cur_tag, "unexpected strobe at addr", mem_addr, 0);
        end else begin
          int k, a, b, w;
          k = ex_kind.pop_front(); a = ex_addr.pop_front();
          b = ex_be.pop_front();   w = ex_wd.pop_front();
          chk(k == int'(mem_wr), cur_tag, "strobe kind (1=wr)", mem_wr, k);
          chk(a == int'(mem_addr), cur_tag, "strobe addr", mem_addr, a);
          if (k == 1) begin
            int m;
            m = (b[0] ? 'h00ff : 0) | (b[1] ? 'hff00 : 0);
            chk(b == int'(mem_be), "R6", "byte enables", mem_be, b);
            chk((int'(mem_wdata) & m) == (w & m), cur_tag, "write data", int'(mem_wdata) & m, w & m);
          end
        end
      end
      prev_wr = mem_wr;
    end
  end

  function automatic int step(int e, int d, int p);
    int dx, dy;
    dx = (d >= 1 && d <= 3) ? 1 : ((d >= 5) ? -1 : 0);
    dy = (d == 0 || d == 1 || d == 7) ? 1 : ((d >= 3 && d <= 5) ? -1 : 0);
    return (((e + dx + dy * p) % 262144) + 262144) % 262144;
  endfunction

  function automatic void model(int t, int m, int dat, int n, int d, int p);
    if (t == 1) return;
    for (int i = 0; i <= n; i++) begin
      logic [15:0] o, r, dd;
      int be;
      o = rrd(ref_ead); dd = 16'(dat);
      if (m != 0) begin
        ex_kind.push_back(0); ex_addr.push_back(ref_ead); ex_be.push_back(0); ex_wd.push_back(0);
      end
      case (m)
        0: r = dd;
        1: r = o ^ dd;
        2: r = o & ~dd;
        default: r = o | dd;
      endcase
      be = (t == 0) ? 3 : ((t == 2) ? 1 : 2);
      ex_kind.push_back(1); ex_addr.push_back(ref_ead); ex_be.push_back(be); ex_wd.push_back(int'(r));
      if (be[0]) o[7:0]  = r[7:0];
      if (be[1]) o[15:8] = r[15:8];
      rmem[ref_ead] = o;
      ref_ead = step(ref_ead, d, p);
    end
  endfunction

  // called at a negedge; returns at the next negedge with the request dropped
  task automatic start(string tag, int t, int m, int dat, int n, int d, int p);
    cur_tag = tag;
    req_type = 2'(t); req_mode = 2'(m); req_data = 16'(dat); req_count = 14'(n);
    dir = 3'(d); pitch = 8'(p); req_valid = 1'b1;
    model(t, m, dat, n, d, p);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle(string tag, int exp_cycles);
    int n = 0;
    while (busy && n < 100000) begin n++; @(negedge clk); end
    chk(n == exp_cycles, tag, "busy cycles", n, exp_cycles);
    chk(ex_kind.size() == 0, tag, "missing strobes", ex_kind.size(), 0);
    chk(int'(ead) == ref_ead, "R8", "execute address", ead, ref_ead);
  endtask

  task automatic load(int a);
    ead_in = 18'(a); ead_load = 1'b1; ref_ead = a;
    @(negedge clk);
    ead_load = 1'b0;
  endtask

  task automatic run(string tag, int t, int m, int dat, int n, int d, int p);
    start(tag, t, m, dat, n, d, p);
    wait_idle(tag, (n + 1) * ((m == 0) ? 1 : 2));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state, sampled while reset is asserted
    chk(!busy && !done && !mem_rd && !mem_wr && mem_be == 0, "R1", "idle outputs", {busy, done, mem_rd, mem_wr}, 0);
    chk(ead == 0, "R1", "reset address", ead, 0);
    rst_n = 1'b1;
    @(negedge clk);

    load('h100);
    run("R2", 0, 0, 'h1234, 0, 2, 40);
    run("R2", 0, 0, 'hbeef, 3, 0, 40);
    run("R3", 0, 1, 'h0ff0, 2, 0, 40);
    run("R3", 2, 1, 'h00a5, 1, 7, 16);
    run("R4", 2, 2, 'h5a0f, 1, 6, 40);
    run("R4", 0, 2, 'hf00f, 2, 1, 20);
    run("R5", 3, 3, 'h8100, 1, 3, 80);
    run("R5", 0, 3, 'h0101, 0, 5, 8);
    run("R6", 3, 0, 'habcd, 2, 2, 40);
    run("R6", 2, 0, 'habcd, 2, 2, 40);

    // R7 rejected target code
    begin
      int e0;
      e0 = int'(ead);
      start("R7", 1, 1, 'hffff, 4, 2, 40);
      repeat (4) begin
        chk(!busy, "R7", "busy after rejected request", busy, 0);
        @(negedge clk);
      end
      chk(int'(ead) == e0, "R7", "address unchanged", ead, e0);
    end

    // R8 wrap and every direction
    load('h3ffff);
    run("R8", 0, 0, 'h1111, 0, 2, 40);
    load(5);
    run("R8", 0, 0, 'h2222, 0, 4, 40);
    for (int d = 0; d < 8; d++) run("R8", 0, 1, 'h0003, 1, d, 100);

    // R9 longer repeat
    run("R9", 0, 3, 'h4000, 5, 1, 3);

    // R11 request and load while busy are ignored
    load('h2000);
    start("R11", 0, 1, 'h00ff, 3, 2, 40);
    req_valid = 1'b1; req_type = 2'd0; req_mode = 2'd0; req_data = 16'hdead;
    ead_load = 1'b1; ead_in = 18'h12345;
    @(negedge clk);
    req_valid = 1'b0; ead_load = 1'b0;
    wait_idle("R11", 7);

    // R12 load together with request acceptance
    cur_tag = "R12";
    ead_in = 18'h00777; ead_load = 1'b1; ref_ead = 'h777;
    start("R12", 0, 2, 'h0f0f, 1, 2, 40);
    ead_load = 1'b0;
    wait_idle("R12", 4);

    // R12 back to back: next request on the final done pulse
    start("R12", 2, 1, 'h00c3, 1, 0, 12);
    while (!done || busy) @(negedge clk);
    chk(!busy && done, "R12", "done with idle", {busy, done}, 1);
    start("R12", 3, 0, 'h7e00, 0, 6, 12);
    wait_idle("R12", 1);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule